// File: doc/BRIEF.md
# Dual-Channel Serial Converter Loader

This block is the digital front end of a pair of 12-bit converters. A single serial data line feeds a 24-bit frame register. One bit is taken on each rising clock edge while the active-low select input is held low. Two update strobes then copy the frame's two 12-bit slots into two output holding registers. A strobe can load either channel alone, or both strobes can load both channels on the same edge. The two held codes are the parallel words that drive the converters.

Each new bit always enters at the top position of the frame register, and everything already in the register moves one place down. Inside each slot the bit order is reversed: the highest position of a slot is that word's LSB. A complete 24-bit frame sent most-significant bit first therefore carries the channel B word first and then the channel A word. The last bit shifted in is the channel A LSB.

An asynchronous active-low clear zeroes the frame register and both held codes at once. The clear overrides shifting and updates. Every other input is synchronous to the one clock. Internally the block runs two small enumerated controls, each decoded with a unique case:

- The frame-register mode has two states, `SH_IDLE` and `SH_SHIFT`. The transition to `SH_SHIFT` happens when select is low, and the return to `SH_IDLE` happens when select is high.
- The update operation has four values: `UPD_NONE`, `UPD_A`, `UPD_B` and `UPD_BOTH`. The value is chosen from the two strobes on every cycle.

Top module: `dac_ld_top`

## Requirements
- R1: While `sel_n` is low, each rising clock edge places `sdin` in frame position 23 and moves the bits in positions 23..1 to positions 22..0. A partial frame of 12 bits therefore turns the old channel A slot into the channel B slot.
- R2: While `sel_n` is high, the frame register does not change, whatever `sdin` does.
- R3: Frame positions 23..12 form the channel A word. Bit k of `code_a` comes from position 23−k, so position 23 is the LSB and position 12 is the MSB.
- R4: Frame positions 11..0 form the channel B word. Bit k of `code_b` comes from position 11−k, so position 11 is the LSB and position 0 is the MSB.
- R5: A rising edge with only `upd_a` high loads `code_a` from the frame and leaves `code_b` unchanged.
- R6: A rising edge with only `upd_b` high loads `code_b` from the frame and leaves `code_a` unchanged.
- R7: A rising edge with both strobes high loads both codes on that same edge.
- R8: A held code keeps its value on every edge where its strobe is low.
- R9: While `clr_n` is low, the frame register and both codes read zero at once, without waiting for a clock edge. The clear overrides select and the strobes.
- R10: An update loads the frame contents as they stood before that edge, even when a shift happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for shifting and updates |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel_n | input | 1 | Select, active low; enables shifting |
| sdin | input | 1 | Serial data, MSB of each word first |
| upd_a | input | 1 | Load channel A from the frame |
| upd_b | input | 1 | Load channel B from the frame |
| code_a | output | 12 | Held channel A code |
| code_b | output | 12 | Held channel B code |

## Verification
A code changes on the first rising edge at which its strobe is sampled high. The bench drives and samples on falling edges, so it checks every strobe effect at the falling edge right after it and checks the absence of an effect at that same point. The clear needs no edge: the bench checks the zeros one nanosecond after `clr_n` falls, again at the next falling edge, and then once more after a strobe that follows the release, which shows the frame register was emptied too. Frame bits are never visible directly, so R1, R2 and R10 are checked through a later update, against a bench model of the frame and against word values written as literals.

// File: rtl/dac_ld_pkg.sv
package dac_ld_pkg;

    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } sh_mode_e;

    // encoding is {upd_b, upd_a}
    typedef enum logic [1:0] {
        UPD_NONE = 2'b00,
        UPD_A    = 2'b01,
        UPD_B    = 2'b10,
        UPD_BOTH = 2'b11
    } upd_op_e;

endpackage

// File: rtl/dac_ld_shreg.sv
module dac_ld_shreg
    import dac_ld_pkg::*;
#(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_q
);

    sh_mode_e mode;

    always_comb begin
        mode = shift_en ? SH_SHIFT : SH_IDLE;
    end

    // new bit enters at the top, older bits move toward position 0
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            frame_q <= '0;
        end else begin
            unique case (mode)
                SH_SHIFT: frame_q <= {din, frame_q[FRAME_W-1:1]};
                SH_IDLE:  frame_q <= frame_q;
            endcase
        end
    end

endmodule

// File: rtl/dac_ld_hold.sv
module dac_ld_hold #(
    parameter int WORD_W  = 12,
    parameter int FRAME_W = 24,
    parameter int SLOT    = 0
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic [WORD_W-1:0]  code
);

    // highest frame position of this slot carries the word's LSB
    localparam int SLOT_TOP = FRAME_W - 1 - SLOT * WORD_W;

    logic [WORD_W-1:0] word_c;

    always_comb begin
        for (int k = 0; k < WORD_W; k++) begin
            word_c[k] = frame[SLOT_TOP - k];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            code <= '0;
        end else if (load) begin
            code <= word_c;
        end
    end

endmodule

// File: rtl/dac_ld_top.sv
module dac_ld_top
    import dac_ld_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              sel_n,
    input  logic              sdin,
    input  logic              upd_a,
    input  logic              upd_b,
    output logic [WORD_W-1:0] code_a,
    output logic [WORD_W-1:0] code_b
);

    localparam int N_CH    = 2;
    localparam int FRAME_W = N_CH * WORD_W;

    logic [FRAME_W-1:0] frame_q;
    upd_op_e            op;
    logic [N_CH-1:0]    ld;
    logic [WORD_W-1:0]  code_arr [N_CH];

    dac_ld_shreg #(
        .FRAME_W (FRAME_W)
    ) u_shreg (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_en (!sel_n),
        .din      (sdin),
        .frame_q  (frame_q)
    );

    always_comb begin
        op = upd_op_e'({upd_b, upd_a});
        unique case (op)
            UPD_NONE: ld = 2'b00;
            UPD_A:    ld = 2'b01;
            UPD_B:    ld = 2'b10;
            UPD_BOTH: ld = 2'b11;
        endcase
    end

    // slot 0 is channel A (upper half), slot 1 is channel B
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        dac_ld_hold #(
            .WORD_W  (WORD_W),
            .FRAME_W (FRAME_W),
            .SLOT    (ch)
        ) u_hold (
            .clk   (clk),
            .clr_n (clr_n),
            .load  (ld[ch]),
            .frame (frame_q),
            .code  (code_arr[ch])
        );
    end

    assign code_a = code_arr[0];
    assign code_b = code_arr[1];

endmodule

// File: rtl/dac_ld_chk.sv
module dac_ld_chk #(
    parameter int WORD_W = 12
) (
    input logic                clk,
    input logic                clr_n,
    input logic                sel_n,
    input logic                sdin,
    input logic                upd_a,
    input logic                upd_b,
    input logic [2*WORD_W-1:0] frame_q,
    input logic [WORD_W-1:0]   code_a,
    input logic [WORD_W-1:0]   code_b
);

    localparam int FW = 2 * WORD_W;

    function automatic logic [WORD_W-1:0] slot_word(input logic [FW-1:0] f, input int s);
        logic [WORD_W-1:0] w;
        for (int k = 0; k < WORD_W; k++) begin
            w[k] = f[FW - 1 - s * WORD_W - k];
        end
        return w;
    endfunction

    a_r1_shift_in: assert property (@(posedge clk) disable iff (!clr_n)
        !sel_n |=> frame_q == {$past(sdin), $past(frame_q[FW-1:1])});

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!clr_n)
        sel_n |=> $stable(frame_q));

    // R3, R5, R7, R10: channel A takes the pre-edge upper slot, reversed
    a_r5_load_a: assert property (@(posedge clk) disable iff (!clr_n)
        upd_a |=> code_a == slot_word($past(frame_q), 0));

    // R4, R6, R7, R10: channel B takes the pre-edge lower slot, reversed
    a_r6_load_b: assert property (@(posedge clk) disable iff (!clr_n)
        upd_b |=> code_b == slot_word($past(frame_q), 1));

    a_r8_hold_a: assert property (@(posedge clk) disable iff (!clr_n)
        !upd_a |=> $stable(code_a));

    a_r8_hold_b: assert property (@(posedge clk) disable iff (!clr_n)
        !upd_b |=> $stable(code_b));

    a_r9_clear: assert property (@(posedge clk)
        !clr_n |-> (frame_q == '0 && code_a == '0 && code_b == '0));

endmodule

bind dac_ld_top dac_ld_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .sel_n   (sel_n),
    .sdin    (sdin),
    .upd_a   (upd_a),
    .upd_b   (upd_b),
    .frame_q (frame_q),
    .code_a  (code_a),
    .code_b  (code_b)
);

// File: tb/sim_dac_ld_top.sv
module sim_dac_ld_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        clr_n, sel_n, sdin, upd_a, upd_b;
    logic [11:0] code_a, code_b;

    dac_ld_top #(.WORD_W(12)) u0 (
        .clk    (clk),
        .clr_n  (clr_n),
        .sel_n  (sel_n),
        .sdin   (sdin),
        .upd_a  (upd_a),
        .upd_b  (upd_b),
        .code_a (code_a),
        .code_b (code_b)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [23:0] m_sr;
    logic [11:0] exp_a, exp_b;

    // reference reassembly: bit k of slot s comes from frame position 23-12*s-k
    function automatic logic [11:0] pick(input logic [23:0] f, input int s);
        logic [11:0] w;
        for (int k = 0; k < 12; k++) begin
            w[k] = f[23 - 12 * s - k];
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // one clock: drive at a falling edge, return at the next falling edge
    task automatic step(input logic s, input logic b, input logic ua, input logic ub);
        sel_n = !s; sdin = b; upd_a = ua; upd_b = ub;
        if (ua) exp_a = pick(m_sr, 0);
        if (ub) exp_b = pick(m_sr, 1);
        if (s)  m_sr  = {b, m_sr[23:1]};
        @(negedge clk);
        sel_n = 1'b1; sdin = 1'b0; upd_a = 1'b0; upd_b = 1'b0;
    endtask

    task automatic send_word(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) step(1'b1, w[i], 1'b0, 1'b0);
    endtask

    // channel B word goes first, channel A word last
    task automatic send_frame(input logic [11:0] wa, input logic [11:0] wb);
        send_word(wb);
        send_word(wa);
    endtask

    task automatic strobe(input logic ua, input logic ub);
        step(1'b0, 1'b0, ua, ub);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        logic [11:0] ra, rb;
        void'($urandom(32'h5EED_2468));
        clr_n = 1'b0; sel_n = 1'b1; sdin = 1'b0; upd_a = 1'b0; upd_b = 1'b0;
        m_sr = '0; exp_a = '0; exp_b = '0;
        repeat (3) @(negedge clk);
        check("R9 reset A", code_a, 12'h000);
        check("R9 reset B", code_b, 12'h000);
        clr_n = 1'b1;
        @(negedge clk);

        // frame without strobe: held codes unchanged
        send_frame(12'hABC, 12'h123);
        check("R8 no strobe A", code_a, 12'h000);
        check("R8 no strobe B", code_b, 12'h000);
        strobe(1'b1, 1'b1);
        check("R3 R7 mapping A", code_a, 12'hABC);
        check("R4 R7 mapping B", code_b, 12'h123);

        // single-channel updates
        send_frame(12'h555, 12'hAAA);
        strobe(1'b1, 1'b0);
        check("R5 A only loads A", code_a, 12'h555);
        check("R5 A only keeps B", code_b, 12'h123);
        strobe(1'b0, 1'b1);
        check("R6 B only loads B", code_b, 12'hAAA);
        check("R6 B only keeps A", code_a, 12'h555);

        // data toggling while deselected is ignored
        for (int i = 0; i < 10; i++) step(1'b0, 1'(i & 1), 1'b0, 1'b0);
        strobe(1'b1, 1'b1);
        check("R2 deselected A", code_a, 12'h555);
        check("R2 deselected B", code_b, 12'hAAA);

        // update on the same edge as a shift takes the old frame
        send_frame(12'h0F0, 12'h70E);
        ra = 12'(($urandom));
        rb = 12'(($urandom));
        step(1'b1, rb[11], 1'b1, 1'b1);
        check("R10 same-edge A", code_a, 12'h0F0);
        check("R10 same-edge B", code_b, 12'h70E);
        for (int i = 10; i >= 0; i--) step(1'b1, rb[i], 1'b0, 1'b0);
        send_word(ra);
        strobe(1'b1, 1'b1);
        check("R1 after split frame A", code_a, ra);
        check("R1 after split frame B", code_b, rb);

        // half frame: old A slot moves into B slot
        send_word(12'h9C3);
        strobe(1'b1, 1'b1);
        check("R1 half frame A", code_a, 12'h9C3);
        check("R1 half frame B", code_b, ra);

        // clear with select and strobes active
        sel_n = 1'b0; sdin = 1'b1; upd_a = 1'b1; upd_b = 1'b1;
        clr_n = 1'b0;
        #1;
        check("R9 async clear A", code_a, 12'h000);
        check("R9 async clear B", code_b, 12'h000);
        @(negedge clk);
        check("R9 clear over strobe A", code_a, 12'h000);
        check("R9 clear over strobe B", code_b, 12'h000);
        sel_n = 1'b1; sdin = 1'b0; upd_a = 1'b0; upd_b = 1'b0;
        clr_n = 1'b1;
        m_sr = '0; exp_a = '0; exp_b = '0;
        strobe(1'b1, 1'b1);
        check("R9 frame cleared A", code_a, 12'h000);
        check("R9 frame cleared B", code_b, 12'h000);

        // random frames with random strobe patterns
        for (int it = 0; it < 40; it++) begin
            int mode;
            ra = 12'($urandom);
            rb = 12'($urandom);
            mode = int'($urandom % 4);
            send_frame(ra, rb);
            strobe(mode[0], mode[1]);
            check("R3 R5 R8 random A", code_a, exp_a);
            check("R4 R6 R8 random B", code_b, exp_b);
            if (mode == 3) begin
                check("R7 random both A", code_a, ra);
                check("R7 random both B", code_b, rb);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule